// File: doc/BRIEF.md
# Ping-Pong Frame Capture Writer

This block sits right behind a parallel camera receiver. It takes an 8-bit pixel stream on the camera pixel clock, together with three qualifier levels: one for frame-active, one for line-active and one for data-valid. It gathers four accepted pixels into one 32-bit word and issues a single write strobe to an external asynchronous SRAM for each word. Each frame goes to one of two memory banks, and the bank changes from frame to frame. While the capture side fills one bank, a downstream processor reads the other.

The write address is not a running count. It is the line number joined to the word position inside the line. Every line therefore starts on a fixed boundary, and a reader can locate a row without knowing how long the rows are. A group of one to three pixels left over when a line or frame ends is written out with zero bytes in its empty lanes. When the frame-active level drops, the block switches banks and raises a one-cycle completion pulse for the processing side.

Top module: `pix_bank_writer`

## Requirements
- R1: While reset is held and in the first cycles after it, `mem_wr` and `frame_done` are 0 and `mem_bank` is 0.
- R2: A pixel counts only on a clock edge where `frame_ok`, `line_ok` and `data_ok` are all 1. Pixels offered with any qualifier low produce no write and do not shift the packing.
- R3: Four counted pixels make one word. The first goes in bits [7:0], the second in [15:8], the third in [23:16] and the fourth in [31:24]. Each complete group causes exactly one write.
- R4: `mem_addr` is {row[9:0], col[8:0]}, a 19-bit value. The column field is the number of words already written in the current line. It returns to 0 when `line_ok` rises.
- R5: The row field goes up by one each time `line_ok` falls. It returns to 0 when `frame_ok` rises.
- R6: If `line_ok` or `frame_ok` falls while one to three pixels are pending, one write goes out with those pixels in the low lanes and zero in every unfilled lane. The write uses the current row and column.
- R7: All writes of a frame carry the same `mem_bank` value. The first frame after reset uses bank 0, and the bank alternates with each frame.
- R8: `frame_done` is high for exactly one cycle per frame. It rises two clock edges after the edge that first samples `frame_ok` low. In that cycle `mem_bank` still names the bank just filled, and it names the other bank from the next cycle on.
- R9: A word's write appears on the outputs two clock edges after the edge that samples its last pixel, or after the edge that samples the closing qualifier edge for a padded group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Camera pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_ok | input | 1 | Frame-active qualifier |
| line_ok | input | 1 | Line-active qualifier |
| data_ok | input | 1 | Data-valid qualifier |
| pix_in | input | 8 | Pixel sample |
| mem_addr | output | 19 | SRAM word address {row, column} |
| mem_data | output | 32 | Packed pixel word |
| mem_wr | output | 1 | Write strobe, one cycle per word |
| mem_bank | output | 1 | Selected SRAM bank |
| frame_done | output | 1 | One-cycle frame completion pulse |

## Verification
The embedded properties check the following on every cycle:
- the completion pulse lasts one cycle;
- the bank changes only together with that pulse;
- no write appears outside a frame;
- the packing lane is empty whenever a line is inactive;
- the column and row fields clear after the line and frame starts.

Other behaviour needs the bench's scenarios:
- the byte placement in each word and the zero padding;
- the exact address sequence across lines of 0 to 9 pixels;
- the two-edge write timing;
- the effect of data-valid gaps, of valid data offered between lines, and of a frame whose last line is cut off by the frame qualifier.

// File: rtl/pbw_pkg.sv
package pbw_pkg;

    // Default geometry of the capture path
    localparam int PIX_W = 8;
    localparam int LANES = 4;
    localparam int ROW_W = 10;
    localparam int COL_W = 9;

    // Qualifier levels and edges as seen by the downstream stages
    typedef struct packed {
        logic fval_lvl;
        logic lval_lvl;
        logic accept;
        logic l_rise;
        logic l_fall;
        logic f_rise;
        logic f_fall;
    } qual_t;

endpackage

// File: rtl/pbw_qual_sync.sv
module pbw_qual_sync #(
    parameter int PIX_W = pbw_pkg::PIX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_ok,
    input  logic             line_ok,
    input  logic             data_ok,
    input  logic [PIX_W-1:0] pix_in,
    output pbw_pkg::qual_t   qual_o,
    output logic [PIX_W-1:0] pix_o
);
    typedef struct packed {
        logic             fv;
        logic             lv;
        logic             dv;
        logic             fv_p;
        logic             lv_p;
        logic [PIX_W-1:0] pix;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fv_p = st_q.fv;
        st_d.lv_p = st_q.lv;
        st_d.fv   = frame_ok;
        st_d.lv   = line_ok;
        st_d.dv   = data_ok;
        st_d.pix  = pix_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        qual_o.fval_lvl = st_q.fv;
        qual_o.lval_lvl = st_q.lv;
        qual_o.accept   = st_q.fv & st_q.lv & st_q.dv;
        qual_o.l_rise   = st_q.lv & ~st_q.lv_p;
        qual_o.l_fall   = ~st_q.lv & st_q.lv_p;
        qual_o.f_rise   = st_q.fv & ~st_q.fv_p;
        qual_o.f_fall   = ~st_q.fv & st_q.fv_p;
        pix_o           = st_q.pix;
    end

endmodule

// File: rtl/pbw_packer.sv
module pbw_packer #(
    parameter int PIX_W = pbw_pkg::PIX_W,
    parameter int LANES = pbw_pkg::LANES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  pbw_pkg::qual_t         qual_i,
    input  logic [PIX_W-1:0]       pix_i,
    output logic                   emit_o,
    output logic [PIX_W*LANES-1:0] word_o
);
    localparam int WORD_W = PIX_W * LANES;
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    typedef struct packed {
        logic [LANE_W-1:0] lane;
        logic [WORD_W-1:0] acc;
    } pack_t;

    pack_t st_d, st_q;
    logic  flush;

    always_comb begin
        st_d   = st_q;
        emit_o = 1'b0;
        word_o = st_q.acc;
        flush  = (qual_i.l_fall | qual_i.f_fall) && (st_q.lane != '0);
        if (qual_i.accept) begin
            word_o[st_q.lane*PIX_W +: PIX_W] = pix_i;
            if (st_q.lane == LAST_LANE) begin
                emit_o    = 1'b1;
                st_d.acc  = '0;
                st_d.lane = '0;
            end else begin
                st_d.acc  = word_o;
                st_d.lane = st_q.lane + 1'b1;
            end
        end else if (flush) begin
            emit_o    = 1'b1;
            st_d.acc  = '0;
            st_d.lane = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_LANE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !qual_i.lval_lvl |=> (st_q.lane == '0)); // R6

endmodule

// File: rtl/pbw_addr_gen.sv
module pbw_addr_gen #(
    parameter int ROW_W  = pbw_pkg::ROW_W,
    parameter int COL_W  = pbw_pkg::COL_W,
    parameter int WORD_W = pbw_pkg::PIX_W * pbw_pkg::LANES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  pbw_pkg::qual_t         qual_i,
    input  logic                   emit_i,
    input  logic [WORD_W-1:0]      word_i,
    output logic [ROW_W+COL_W-1:0] mem_addr,
    output logic [WORD_W-1:0]      mem_data,
    output logic                   mem_wr,
    output logic                   mem_bank,
    output logic                   frame_done
);
    localparam int ADDR_W = ROW_W + COL_W;

    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              bank;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic              wr;
        logic              obank;
        logic              irq;
    } agen_t;

    agen_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.wr    = 1'b0;
        st_d.irq   = qual_i.f_fall;
        st_d.obank = st_q.bank;
        if (emit_i) begin
            st_d.wr   = 1'b1;
            st_d.addr = {st_q.row, st_q.col};
            st_d.data = word_i;
            st_d.col  = st_q.col + 1'b1;
        end
        if (qual_i.l_fall) st_d.row = st_q.row + 1'b1;
        if (qual_i.l_rise) st_d.col = '0;
        if (qual_i.f_rise) begin
            st_d.row = '0;
            st_d.col = '0;
        end
        if (qual_i.f_fall) st_d.bank = ~st_q.bank;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_addr   = st_q.addr;
    assign mem_data   = st_q.data;
    assign mem_wr     = st_q.wr;
    assign mem_bank   = st_q.obank;
    assign frame_done = st_q.irq;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |=> !st_q.irq); // R8

    AST_BANK_AT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.bank != $past(st_q.bank)) |-> st_q.irq); // R7

    AST_WR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr |-> ($past(qual_i.fval_lvl) || $past(qual_i.f_fall))); // R2

    AST_COL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        qual_i.l_rise |=> (st_q.col == '0)); // R4

    AST_ROW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        qual_i.f_rise |=> (st_q.row == '0)); // R5

endmodule

// File: rtl/pix_bank_writer.sv
module pix_bank_writer #(
    parameter int PIX_W = pbw_pkg::PIX_W,
    parameter int LANES = pbw_pkg::LANES,
    parameter int ROW_W = pbw_pkg::ROW_W,
    parameter int COL_W = pbw_pkg::COL_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_ok,
    input  logic                         line_ok,
    input  logic                         data_ok,
    input  logic [PIX_W-1:0]             pix_in,
    output logic [ROW_W+COL_W-1:0]       mem_addr,
    output logic [PIX_W*LANES-1:0]       mem_data,
    output logic                         mem_wr,
    output logic                         mem_bank,
    output logic                         frame_done
);
    localparam int WORD_W = PIX_W * LANES;

    pbw_pkg::qual_t    qual;
    logic [PIX_W-1:0]  pix_s;
    logic              emit;
    logic [WORD_W-1:0] word;

    pbw_qual_sync #(.PIX_W(PIX_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_ok (frame_ok),
        .line_ok  (line_ok),
        .data_ok  (data_ok),
        .pix_in   (pix_in),
        .qual_o   (qual),
        .pix_o    (pix_s)
    );

    pbw_packer #(.PIX_W(PIX_W), .LANES(LANES)) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .qual_i (qual),
        .pix_i  (pix_s),
        .emit_o (emit),
        .word_o (word)
    );

    pbw_addr_gen #(.ROW_W(ROW_W), .COL_W(COL_W), .WORD_W(WORD_W)) u_agen (
        .clk        (clk),
        .rst_n      (rst_n),
        .qual_i     (qual),
        .emit_i     (emit),
        .word_i     (word),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .mem_wr     (mem_wr),
        .mem_bank   (mem_bank),
        .frame_done (frame_done)
    );

endmodule

// File: tb/pix_bank_writer_test.sv
module pix_bank_writer_test;
    localparam int COL_W = 9;
    localparam int ROW_W = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_ok = 1'b0, line_ok = 1'b0, data_ok = 1'b0;
    logic [7:0]  pix_in = '0;
    logic [18:0] mem_addr;
    logic [31:0] mem_data;
    logic        mem_wr, mem_bank, frame_done;

    pix_bank_writer uut (
        .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .line_ok(line_ok),
        .data_ok(data_ok), .pix_in(pix_in), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_wr(mem_wr), .mem_bank(mem_bank),
        .frame_done(frame_done)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // expected outputs, two cycles ahead of the drive step
    logic        e_wr[4], e_irq[4], e_bank[4], e_pad[4];
    logic [18:0] e_addr[4];
    logic [31:0] e_data[4];

    // specification model state
    logic        pf = 0, pl = 0, mbank = 0;
    int          lane = 0;
    logic [31:0] acc = '0;
    logic [ROW_W-1:0] row = '0;
    logic [COL_W-1:0] col = '0;
    int          t = 0;

    task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at step %0d: actual=%h expected=%h", tag, t, act, exp);
        end
    endtask

    task automatic step(logic f, logic l, logic d, logic [7:0] px);
        int s, n;
        logic acc_ok, lr, lf, fr, ff;
        @(negedge clk);
        s = t % 4;
        check_val("R2 R9 write strobe", 32'(mem_wr), 32'(e_wr[s]));
        if (e_wr[s] && mem_wr) begin
            check_val(e_pad[s] ? "R6 padded word" : "R3 packed word", mem_data, e_data[s]);
            check_val("R4 column field", 32'(mem_addr[COL_W-1:0]), 32'(e_addr[s][COL_W-1:0]));
            check_val("R5 row field", 32'(mem_addr[18:COL_W]), 32'(e_addr[s][18:COL_W]));
        end
        check_val("R8 frame pulse", 32'(frame_done), 32'(e_irq[s]));
        check_val("R7 bank select", 32'(mem_bank), 32'(e_bank[s]));

        frame_ok = f; line_ok = l; data_ok = d; pix_in = px;
        acc_ok = f & l & d;
        lr = l & ~pl; lf = ~l & pl; fr = f & ~pf; ff = ~f & pf;
        n = (t + 2) % 4;
        e_wr[n] = 0; e_pad[n] = 0; e_irq[n] = ff; e_bank[n] = mbank;
        if (acc_ok) begin
            acc[lane*8 +: 8] = px;
            if (lane == 3) begin
                e_wr[n] = 1; e_data[n] = acc; e_addr[n] = {row, col};
                col = col + 1'b1; lane = 0; acc = '0;
            end else lane++;
        end else if ((lf | ff) && lane != 0) begin
            e_wr[n] = 1; e_pad[n] = 1; e_data[n] = acc; e_addr[n] = {row, col};
            col = col + 1'b1; lane = 0; acc = '0;
        end
        if (lf) row = row + 1'b1;
        if (lr) col = '0;
        if (fr) begin row = '0; col = '0; end
        if (ff) mbank = ~mbank;
        pf = f; pl = l;
        t++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            e_wr[i] = 0; e_irq[i] = 0; e_bank[i] = 0; e_pad[i] = 0;
            e_addr[i] = '0; e_data[i] = '0;
        end
        repeat (4) @(negedge clk);
        // R1: outputs quiet while reset is held
        check_val("R1 reset write", 32'(mem_wr), 32'd0);
        check_val("R1 reset pulse", 32'(frame_done), 32'd0);
        check_val("R1 reset bank", 32'(mem_bank), 32'd0);
        rst_n = 1'b1;

        for (int fi = 0; fi < 6; fi++) begin
            int nl;
            nl = 2 + fi % 3;
            // valid data outside any frame must be ignored (R2)
            for (int k = 0; k < 3; k++) step(0, 0, 1, 8'(t * 5 + 1));
            step(1, 0, 1, 8'hEE);
            for (int li = 0; li < nl; li++) begin
                int len;
                len = (fi * 3 + li * 5) % 10;
                if (len == 0) begin
                    step(1, 1, 0, 8'hAA);
                    step(1, 1, 0, 8'h55);
                end
                for (int k = 0; k < len; k++) begin
                    if ((fi % 2 == 1) && (k % 3 == 1)) step(1, 1, 0, 8'hCC);
                    step(1, 1, 1, 8'(t * 7 + 3));
                end
                if (fi == 5 && li == nl - 1) begin
                    // frame qualifier drops together with the line (R6)
                    step(0, 0, 1, 8'h11);
                end else begin
                    step(1, 0, 1, 8'h77);
                    step(1, 0, 0, 8'h66);
                end
            end
            if (fi != 5) begin
                step(1, 0, 0, 8'h00);
                step(0, 0, 0, 8'h00);
            end
        end
        for (int k = 0; k < 6; k++) step(0, 0, 0, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule